// File: doc/BRIEF.md
# Multichannel Event Scaler Bank

This block holds a bank of independent binary event counters. Every counter has a shadow buffer register that the host reads in place of the live count, and a sticky wrap flag. Each count input is an asynchronous single-bit pulse line. The line passes through a two-flop synchronizer, and its rising edge advances the counter. Counting needs three conditions at once: the global run enable is on, the inhibit input is off, and the gate, if one is in use, is open.

A controller picks one of three buffer-load policies. In the read-load policy, a host read of a channel first captures that channel's live count. In the command policy, a latch strobe snapshots every counter in the same cycle and counting carries on. In the gate-end policy, the falling edge of the gate snapshots every counter, and the counters can then be cleared. An increment strobe advances all counters by one together. The host reads buffers and the packed wrap flags through a one-cycle registered read port.

Top module: `scaler_bank`

## Requirements
- R1: After reset all counters, buffers and wrap flags are zero, and rd_valid_o is low.
- R2: When counting is allowed, each rising edge of a channel's synchronized input adds one to that channel's 24-bit counter, and other channels are not affected.
- R3: Counting is suppressed when run_en_i is 0, when inhibit_i is 1, or when gate_use_i is 1 and gate_i is 0.
- R4: With mode_i = 1 (read-load), a buffer read first loads that channel's buffer with its live count and returns that count.
- R5: With mode_i = 0 (command), a latch_i pulse copies every counter into its buffer in the same cycle. A buffer read in this mode does not reload the buffer.
- R6: With mode_i = 2 (gate-end), a 1-to-0 transition of gate_i copies every counter into its buffer. If gate_clr_en_i is 1, every counter is also cleared in that cycle.
- R7: A channel's wrap flag sets when its counter steps from all ones to zero. The flag stays set through counter clears, and only an ovf_clr_i pulse resets it.
- R8: Read address NCH returns the wrap flags of channels 0 to 15 in bits 15:0. Address NCH+1 returns channels 16 to 31 in bits 15:0. Bits 31:16 are zero in both.
- R9: Read data for a request on rd_en_i appears on rd_data_o with rd_valid_o high on the next cycle. A buffer word carries the count in bits 23:0 and zeros in bits 31:24.
- R10: An incr_i pulse adds one to every counter, whatever the state of run enable, inhibit or gate.
- R11: When a buffer load and an increment fall in the same cycle, the buffer takes the value from before the increment. A clear in the same cycle as an increment leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_in_i | input | NCH | Asynchronous count pulse lines, one per channel |
| run_en_i | input | 1 | Global count enable |
| inhibit_i | input | 1 | Global inhibit, active high |
| gate_i | input | 1 | Gate level, high means open |
| gate_use_i | input | 1 | Gate qualifies counting when 1 |
| mode_i | input | 2 | Buffer-load policy: 0 command, 1 read-load, 2 gate-end (3 acts as command) |
| gate_clr_en_i | input | 1 | Clear counters after a gate-end load |
| latch_i | input | 1 | Snapshot strobe for command policy |
| incr_i | input | 1 | Add one to all counters |
| ovf_clr_i | input | 1 | Clear all wrap flags |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | 0..NCH-1 buffers, NCH and up wrap-flag words |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
Pulse trains go to random channel masks, and after a snapshot every channel is compared with a bench model. A count bleeding into a neighbour or a lost edge shows up as a mismatch. The same trains are repeated with run enable off, with inhibit on and with the gate closed, which shows that each qualifier blocks counts on its own. The tests then cover a read-load read followed by a command-policy read of the same buffer, and gate falls with and without clearing. A latch or gate fall issued in the same cycle as an increment shows the pre-increment capture and the priority of clear. A second instance with a 6-bit width drives selected channels through wraparound, which exercises flag placement in both words and flag retention through clears.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  typedef enum logic [1:0] {
    LOAD_CMD  = 2'd0,
    LOAD_READ = 2'd1,
    LOAD_GATE = 2'd2
  } load_mode_e;
endpackage

// File: rtl/scaler_sync_edge.sv
module scaler_sync_edge #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_en_i,
  input  logic       inhibit_i,
  input  logic       gate_i,
  input  logic       gate_use_i,
  input  logic [1:0] mode_i,
  input  logic       gate_clr_en_i,
  input  logic       latch_i,
  output logic       cnt_ok_o,
  output logic       xfer_all_o,
  output logic       clr_all_o,
  output logic       rd_load_o
);
  logic gate_prev_q;
  logic gate_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_prev_q <= 1'b0;
    else         gate_prev_q <= gate_i;
  end

  assign gate_end   = gate_prev_q & ~gate_i & (mode_i == LOAD_GATE);
  assign cnt_ok_o   = run_en_i & ~inhibit_i & (~gate_use_i | gate_i);
  assign rd_load_o  = (mode_i == LOAD_READ);
  assign xfer_all_o = gate_end | (latch_i & ~rd_load_o & (mode_i != LOAD_GATE));
  assign clr_all_o  = gate_end & gate_clr_en_i;
endmodule

// File: rtl/scaler_chan.sv
module scaler_chan #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             xfer_i,
  input  logic             clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] buf_o,
  output logic             ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      buf_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      // clear beats increment; buffer sees the pre-update count
      if (clr_i)      cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
      if (xfer_i) buf_o <= cnt_o;
      if (inc_i && !clr_i && (&cnt_o)) ovf_o <= 1'b1;
      else if (ovf_clr_i)              ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
  import scaler_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NCH + (NCH + 15) / 16)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    cnt_in_i,
  input  logic              run_en_i,
  input  logic              inhibit_i,
  input  logic              gate_i,
  input  logic              gate_use_i,
  input  logic [1:0]        mode_i,
  input  logic              gate_clr_en_i,
  input  logic              latch_i,
  input  logic              incr_i,
  input  logic              ovf_clr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int OVF_WORDS = (NCH + 15) / 16;
  localparam int OVF_BITS  = OVF_WORDS * 16;
  localparam int CH_W      = $clog2(NCH);

  logic [NCH-1:0]       rise;
  logic [NCH-1:0]       ovf_q;
  logic [NCH*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]     cnt_arr [NCH];
  logic [CNT_W-1:0]     buf_arr [NCH];
  logic [OVF_BITS-1:0]  ovf_pad;
  logic                 cnt_ok, xfer_all, clr_all, rd_load;
  logic [DATA_W-1:0]    rd_mux;
  logic [CH_W-1:0]      sel;

  scaler_sync_edge #(.N(NCH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cnt_in_i),
    .rise_o  (rise)
  );

  scaler_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_en_i      (run_en_i),
    .inhibit_i     (inhibit_i),
    .gate_i        (gate_i),
    .gate_use_i    (gate_use_i),
    .mode_i        (mode_i),
    .gate_clr_en_i (gate_clr_en_i),
    .latch_i       (latch_i),
    .cnt_ok_o      (cnt_ok),
    .xfer_all_o    (xfer_all),
    .clr_all_o     (clr_all),
    .rd_load_o     (rd_load)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic inc, xfer;
    assign inc  = (rise[g] & cnt_ok) | incr_i;
    assign xfer = xfer_all | (rd_load & rd_en_i & (rd_addr_i == ADDR_W'(g)));

    scaler_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc),
      .xfer_i    (xfer),
      .clr_i     (clr_all),
      .ovf_clr_i (ovf_clr_i),
      .cnt_o     (cnt_arr[g]),
      .buf_o     (buf_arr[g]),
      .ovf_o     (ovf_q[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_arr[g];
  end

  assign ovf_pad = OVF_BITS'(ovf_q);
  assign sel     = rd_addr_i[CH_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i < ADDR_W'(NCH)) begin
      rd_mux = DATA_W'(rd_load ? cnt_arr[sel] : buf_arr[sel]);
    end
    for (int k = 0; k < OVF_WORDS; k++) begin
      if (rd_addr_i == ADDR_W'(NCH + k)) rd_mux = DATA_W'(ovf_pad[k*16 +: 16]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/scaler_bank_chk.sv
module scaler_bank_chk #(
  parameter int NCH    = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_en_i,
  input logic [ADDR_W-1:0]    rd_addr_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic                 rd_valid_o,
  input logic                 run_en_i,
  input logic                 incr_i,
  input logic                 ovf_clr_i,
  input logic [NCH-1:0]       ovf_q,
  input logic [NCH*CNT_W-1:0] cnt_flat,
  input logic                 clr_all
);
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  a_r1_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (rd_addr_i < ADDR_W'(NCH))) |=> ((rd_data_o >> CNT_W) == '0));

  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !incr_i && !clr_all) |=> $stable(cnt_flat));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_clr_i |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all |=> (cnt_flat == '0));

  a_r10_incr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !clr_all) |=> (cnt_flat != $past(cnt_flat)));
endmodule

bind scaler_bank scaler_bank_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .run_en_i   (run_en_i),
  .incr_i     (incr_i),
  .ovf_clr_i  (ovf_clr_i),
  .ovf_q      (ovf_q),
  .cnt_flat   (cnt_flat),
  .clr_all    (clr_all)
);

// File: tb/sim_scaler_bank.sv
`timescale 1ns/1ps
module sim_scaler_bank;
  localparam int NCH = 32;
  localparam int AW  = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] cnt_in_i = '0;
  logic run_en_i = 0, inhibit_i = 0, gate_i = 0, gate_use_i = 0;
  logic [1:0] mode_i = 2'd0;
  logic gate_clr_en_i = 0, latch_i = 0, incr_i = 0, ovf_clr_i = 0, rd_en_i = 0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0] rd0, rd1;
  logic v0, v1;

  int errors = 0;
  int checks = 0;

  logic [23:0] c0 [NCH];
  logic [5:0]  c1 [NCH];
  logic [23:0] b0 [NCH];
  logic [5:0]  b1 [NCH];
  logic [31:0] o0, o1;

  always #4 clk_i = ~clk_i;

  scaler_bank u0 (
    .clk_i, .rst_ni, .cnt_in_i, .run_en_i, .inhibit_i, .gate_i, .gate_use_i,
    .mode_i, .gate_clr_en_i, .latch_i, .incr_i, .ovf_clr_i, .rd_en_i, .rd_addr_i,
    .rd_data_o(rd0), .rd_valid_o(v0)
  );

  scaler_bank #(.CNT_W(6)) u1 (
    .clk_i, .rst_ni, .cnt_in_i, .run_en_i, .inhibit_i, .gate_i, .gate_use_i,
    .mode_i, .gate_clr_en_i, .latch_i, .incr_i, .ovf_clr_i, .rd_en_i, .rd_addr_i,
    .rd_data_o(rd1), .rd_valid_o(v1)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic void bump(input int ch);
    c0[ch] = c0[ch] + 24'd1;
    if (c0[ch] == 24'd0) o0[ch] = 1'b1;
    c1[ch] = c1[ch] + 6'd1;
    if (c1[ch] == 6'd0) o1[ch] = 1'b1;
  endfunction

  function automatic logic [31:0] exp_rd(input int inst, input int a);
    if (a < NCH) return (inst == 0) ? {8'd0, b0[a]} : {26'd0, b1[a]};
    if (a == NCH) return (inst == 0) ? {16'd0, o0[15:0]} : {16'd0, o1[15:0]};
    return (inst == 0) ? {16'd0, o0[31:16]} : {16'd0, o1[31:16]};
  endfunction

  task automatic ctl(input logic [1:0] m, input logic run, input logic inh,
                     input logic guse, input logic gclr);
    mode_i = m; run_en_i = run; inhibit_i = inh; gate_use_i = guse; gate_clr_en_i = gclr;
    tick();
  endtask

  task automatic pulse(input logic [31:0] m);
    logic ok;
    ok = run_en_i & ~inhibit_i & (~gate_use_i | gate_i);
    cnt_in_i = m;
    tick(); tick();
    cnt_in_i = '0;
    tick(); tick();
    if (ok) for (int ch = 0; ch < NCH; ch++) if (m[ch]) bump(ch);
  endtask

  task automatic incr();
    incr_i = 1'b1; tick(); incr_i = 1'b0;
    for (int ch = 0; ch < NCH; ch++) bump(ch);
  endtask

  task automatic latch(input logic with_incr);
    latch_i = 1'b1; incr_i = with_incr; tick(); latch_i = 1'b0; incr_i = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      b0[ch] = c0[ch]; b1[ch] = c1[ch];
      if (with_incr) bump(ch);
    end
  endtask

  task automatic gate_fall(input logic with_incr);
    gate_i = 1'b0; incr_i = with_incr; tick(); incr_i = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      b0[ch] = c0[ch]; b1[ch] = c1[ch];
      if (gate_clr_en_i) begin c0[ch] = '0; c1[ch] = '0; end
      else if (with_incr) bump(ch);
    end
  endtask

  task automatic rd(input string tag, input int a);
    if (mode_i == 2'd1 && a < NCH) begin b0[a] = c0[a]; b1[a] = c1[a]; end
    rd_en_i = 1'b1; rd_addr_i = AW'(a);
    tick();
    rd_en_i = 1'b0;
    chk({tag, " valid"}, {31'd0, v0}, 32'd1);
    chk({tag, " u0"}, rd0, exp_rd(0, a));
    chk({tag, " u1"}, rd1, exp_rd(1, a));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int ch = 0; ch < NCH; ch++) begin c0[ch] = 0; c1[ch] = 0; b0[ch] = 0; b1[ch] = 0; end
    o0 = '0; o1 = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 valid low", {31'd0, v0}, 32'd0);
    rd("R1 buf0", 0); rd("R1 buf31", 31); rd("R1 ovf lo", 32); rd("R1 ovf hi", 33);

    // R2 R5 R9: counts land only on pulsed channels
    ctl(2'd0, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) pulse($urandom());
    pulse(32'hA5A5_0001);
    latch(0);
    for (int ch = 0; ch < NCH; ch++) rd("R2 chan", ch);

    // R3: each qualifier blocks counting
    ctl(2'd0, 0, 0, 0, 0); pulse(32'hFFFF_FFFF);
    ctl(2'd0, 1, 1, 0, 0); pulse(32'hFFFF_FFFF);
    ctl(2'd0, 1, 0, 1, 0); pulse(32'hFFFF_FFFF);
    latch(0);
    rd("R3 blocked c3", 3); rd("R3 blocked c30", 30);
    gate_i = 1'b1; tick(); pulse(32'h0000_0018);
    gate_i = 1'b0; tick();
    latch(0);
    rd("R3 gate open c3", 3); rd("R3 gate open c4", 4);

    // R5: no reload on read in command mode
    ctl(2'd0, 1, 0, 0, 0);
    pulse(32'h0000_0100);
    rd("R5 stale c8", 8);

    // R4: read-load then command-mode read of same buffer
    ctl(2'd1, 1, 0, 0, 0);
    pulse(32'h0000_0200);
    rd("R4 live c9", 9);
    ctl(2'd0, 1, 0, 0, 0);
    pulse(32'h0000_0200);
    rd("R4 held c9", 9);

    // R10: increment ignores qualifiers
    ctl(2'd0, 0, 1, 1, 0);
    incr(); incr();
    latch(0);
    rd("R10 c0", 0); rd("R10 c17", 17);

    // R11: latch with increment captures pre value
    latch(1);
    rd("R11 pre c5", 5);
    latch(0);
    rd("R11 post c5", 5);

    // R6: gate-end loads, with and without clear
    ctl(2'd2, 1, 0, 1, 0);
    gate_i = 1'b1; tick();
    pulse(32'h0001_0040);
    gate_fall(0);
    rd("R6 noclr c6", 6); rd("R6 noclr c16", 16);
    ctl(2'd2, 1, 0, 1, 1);
    gate_i = 1'b1; tick();
    pulse(32'h0000_0040);
    gate_fall(1);
    rd("R6 clr c6", 6);
    ctl(2'd0, 1, 0, 0, 0);
    latch(0);
    rd("R11 clear wins c6", 6); rd("R6 zero c20", 20);

    // R7 R8: wrap selected channels on the narrow instance
    for (int i = 0; i < 66; i++) pulse(32'h8001_0003);
    rd("R8 ovf lo", 32); rd("R8 ovf hi", 33);
    ctl(2'd2, 1, 0, 1, 1);
    gate_i = 1'b1; tick();
    gate_fall(0);
    rd("R7 kept lo", 32); rd("R7 kept hi", 33);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
    o0 = '0; o1 = '0;
    rd("R7 cleared lo", 32); rd("R7 cleared hi", 33);

    // random mix in command mode
    ctl(2'd0, 1, 0, 0, 0);
    for (int i = 0; i < 120; i++) begin
      case ($urandom_range(0, 4))
        0: begin
          run_en_i = ($urandom_range(0, 3) != 0);
          inhibit_i = ($urandom_range(0, 3) == 0);
          tick();
          pulse($urandom());
        end
        1: incr();
        2: latch($urandom_range(0, 1) == 1);
        default: rd("R2 random", $urandom_range(0, NCH + 1));
      endcase
    end
    latch(0);
    for (int ch = 0; ch < NCH; ch++) rd("R2 final", ch);
    rd("R8 final lo", 32); rd("R8 final hi", 33);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule